// File: doc/BRIEF.md
# Level-Gated Software Interrupt Register

This block keeps one processor's software interrupt word and turns it into a bank of interrupt-request levels. Each level is gated by the processor's current interrupt level, a 4-bit value held in the block. The word is 17 bits wide. Bits 1 to 15 are ordinary software requests, and each one passes only when its own index is above the current level. Bit 0 is the timer match bit and bit 16 is the system-timer match bit. These two share one fixed gate: they pass only while the level is below 14.

Software reaches the block through a small register-address bus with four locations. Location 0 loads the word directly. Location 1 ORs the written data into the word. Location 2 clears every bit where the written data holds a one. Location 3 loads the interrupt level. A timer strobe sets bit 0 in hardware. Reads are combinational. Location 3 returns the level, zero-extended, and every other location returns the raw word. The request levels are registered. They follow the word and the level with one clock of delay, so any write to either one re-evaluates every line. Deciding between lines and delivering traps belong to the consumer.

Top module: `swint_mask_unit`

## Requirements
- R1: After reset the word is 0, the interrupt level is 15 and every request output is 0.
- R2: A write to location 0 (wr_addr = 0) loads wr_data[16:0] into the word. Bits 31 to 17 are discarded and read back as 0.
- R3: A write to location 1 (wr_addr = 1) sets every word bit whose wr_data bit is 1 and leaves the other bits unchanged.
- R4: A write to location 2 (wr_addr = 2) clears every word bit whose wr_data bit is 1 and leaves the other bits unchanged.
- R5: A high timer_hit sets word bit 0 at that clock edge. When it arrives in the same cycle as a bus write, the bus operation is applied first and the strobe second, so bit 0 ends set even if that write clears it.
- R6: For bits 1 to 15, irq_req[k] is 1 exactly when word bit k is 1 and k is strictly greater than the interrupt level.
- R7: irq_req[0] and irq_req[16] are 1 exactly when the matching word bit is 1 and the interrupt level is below 14.
- R8: A write to location 3 (wr_addr = 3) loads wr_data[3:0] into the interrupt level. A read of location 3 returns the level in bits 3:0 with zeros above.
- R9: irq_req is registered. After the word or the level changes at a clock edge, the outputs show the new gating at the next edge, and at no other time.
- R10: Reads of locations 0, 1 and 2 all return the raw word, zero-extended to 32 bits. The read path is combinational from rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register bus |
| wr_addr | input | 2 | Write location: 0 load, 1 set, 2 clear, 3 level |
| wr_data | input | 32 | Write data |
| timer_hit | input | 1 | Hardware strobe that sets word bit 0 |
| rd_addr | input | 2 | Read location |
| rd_data | output | 32 | Read data: the word, or the level at location 3 |
| irq_req | output | 17 | Gated request level for each word bit |

## Verification
The assertions assume that reset is held across at least one rising clock edge. They also assume that wr_en, wr_addr, wr_data and timer_hit carry known values at every sampled edge outside reset, because each relation compares the state after an edge with the inputs that went into it. The clear-alias property is further qualified by the absence of a timer strobe, since the strobe may legally put bit 0 back in the same cycle. The stimulus changes inputs only on falling edges and always drives defined values, including over-wide data words and level values at and around the fixed threshold of 14.

// File: rtl/swint_pkg.sv
package swint_pkg;

    // Register-bus locations. The set and clear aliases rely on this ordering
    // only for decoding; reads of every location except the level return the word.
    localparam int ADR_W = 2;
    localparam logic [ADR_W-1:0] ADR_LOAD  = 2'd0;
    localparam logic [ADR_W-1:0] ADR_SET   = 2'd1;
    localparam logic [ADR_W-1:0] ADR_CLEAR = 2'd2;
    localparam logic [ADR_W-1:0] ADR_LEVEL = 2'd3;

    // Operation applied to the state in one cycle.
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOAD,
        OP_SET,
        OP_CLEAR,
        OP_LEVEL
    } swint_op_e;

endpackage

// File: rtl/swint_wr_decode.sv
module swint_wr_decode
    import swint_pkg::*;
(
    input  logic             wr_en,
    input  logic [ADR_W-1:0] wr_addr,
    output swint_op_e        op
);

    // Turn the bus strobe and location into a single operation code.
    always_comb begin
        op = OP_IDLE;
        if (wr_en) begin
            unique case (wr_addr)
                ADR_LOAD:  op = OP_LOAD;
                ADR_SET:   op = OP_SET;
                ADR_CLEAR: op = OP_CLEAR;
                ADR_LEVEL: op = OP_LEVEL;
                default:   op = OP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/swint_reg_core.sv
module swint_reg_core
    import swint_pkg::*;
#(
    parameter int SI_W    = 17,
    parameter int PIL_W   = 4,
    parameter int DATA_W  = 32,
    parameter int HIT_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  swint_op_e         op,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              timer_hit,
    output logic [SI_W-1:0]   soft_q,
    output logic [PIL_W-1:0]  level_q
);

    logic [SI_W-1:0]  wdat;
    logic [SI_W-1:0]  after_bus;
    logic [SI_W-1:0]  soft_d;
    logic [PIL_W-1:0] level_d;

    // Only the low SI_W bits of the bus take part in any word update.
    assign wdat = wr_data[SI_W-1:0];

    // The bus operation is applied first.
    always_comb begin
        after_bus = soft_q;
        unique case (op)
            OP_LOAD:  after_bus = wdat;
            OP_SET:   after_bus = soft_q | wdat;
            OP_CLEAR: after_bus = soft_q & ~wdat;
            default:  after_bus = soft_q;
        endcase
    end

    // The timer strobe is applied after the bus, so it always survives.
    always_comb begin
        soft_d = after_bus;
        if (timer_hit) begin
            soft_d[HIT_BIT] = 1'b1;
        end
    end

    assign level_d = (op == OP_LEVEL) ? wr_data[PIL_W-1:0] : level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_q  <= '0;
            level_q <= '1;
        end else begin
            soft_q  <= soft_d;
            level_q <= level_d;
        end
    end

endmodule

// File: rtl/swint_req_gate.sv
module swint_req_gate #(
    parameter int          SI_W        = 17,
    parameter int          PIL_W       = 4,
    parameter int unsigned FIXED_LIMIT = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SI_W-1:0]  soft_q,
    input  logic [PIL_W-1:0] level_q,
    output logic [SI_W-1:0]  irq_q
);

    localparam logic [31:0] LIMIT32 = 32'(FIXED_LIMIT);

    logic [31:0]     level32;
    logic            below_fixed;
    logic [SI_W-1:0] eligible;

    assign level32     = 32'(level_q);
    assign below_fixed = level32 < LIMIT32;

    // The two end bits use the fixed threshold; the middle bits compare
    // their own index with the level.
    for (genvar k = 0; k < SI_W; k++) begin : g_bit
        localparam logic [31:0] IDX = 32'(k);
        if (k == 0 || k == SI_W - 1) begin : g_fixed
            assign eligible[k] = soft_q[k] & below_fixed;
        end else begin : g_indexed
            assign eligible[k] = soft_q[k] & (level32 < IDX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= eligible;
        end
    end

endmodule

// File: rtl/swint_mask_unit.sv
module swint_mask_unit
    import swint_pkg::*;
#(
    parameter int          SI_W        = 17,
    parameter int          PIL_W       = 4,
    parameter int          DATA_W      = 32,
    parameter int unsigned FIXED_LIMIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              timer_hit,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [SI_W-1:0]   irq_req
);

    swint_op_e        op;
    logic [SI_W-1:0]  soft_q;
    logic [PIL_W-1:0] level_q;

    swint_wr_decode u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .op      (op)
    );

    swint_reg_core #(
        .SI_W    (SI_W),
        .PIL_W   (PIL_W),
        .DATA_W  (DATA_W),
        .HIT_BIT (0)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .wr_data   (wr_data),
        .timer_hit (timer_hit),
        .soft_q    (soft_q),
        .level_q   (level_q)
    );

    swint_req_gate #(
        .SI_W        (SI_W),
        .PIL_W       (PIL_W),
        .FIXED_LIMIT (FIXED_LIMIT)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_q  (soft_q),
        .level_q (level_q),
        .irq_q   (irq_req)
    );

    // Combinational read: the level at its own location, the word elsewhere.
    always_comb begin
        if (rd_addr == ADR_LEVEL) begin
            rd_data = DATA_W'(level_q);
        end else begin
            rd_data = DATA_W'(soft_q);
        end
    end

endmodule

// File: rtl/swint_mask_chk.sv
module swint_mask_chk
    import swint_pkg::*;
#(
    parameter int          SI_W        = 17,
    parameter int          PIL_W       = 4,
    parameter int          DATA_W      = 32,
    parameter int unsigned FIXED_LIMIT = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              timer_hit,
    input logic [SI_W-1:0]   soft_q,
    input logic [PIL_W-1:0]  level_q,
    input logic [SI_W-1:0]   irq_req
);

    localparam logic [31:0] LIMIT32 = 32'(FIXED_LIMIT);

    // R2: a plain load without a strobe leaves exactly the low data bits.
    a_r2_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_LOAD && !timer_hit)
        |=> soft_q == $past(wr_data[SI_W-1:0]));

    // R3: every bit written as one is set afterwards.
    a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_SET)
        |=> (soft_q & $past(wr_data[SI_W-1:0])) == $past(wr_data[SI_W-1:0]));

    // R4: every bit written as one is clear afterwards (no strobe present).
    a_r4_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_CLEAR && !timer_hit)
        |=> (soft_q & $past(wr_data[SI_W-1:0])) == '0);

    // R5: the strobe always leaves bit 0 set.
    a_r5_strobe_wins: assert property (@(posedge clk) disable iff (!rst_n)
        timer_hit |=> soft_q[0]);

    // R8: a level write takes the low data bits.
    a_r8_level_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_LEVEL)
        |=> level_q == $past(wr_data[PIL_W-1:0]));

    // R7 and R9: end bits follow the fixed threshold one cycle late.
    a_r7_low_end: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[0] == ($past(soft_q[0]) && (32'($past(level_q)) < LIMIT32)));

    a_r7_high_end: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[SI_W-1] == ($past(soft_q[SI_W-1]) && (32'($past(level_q)) < LIMIT32)));

    // R6 and R9: middle bits follow their index comparison one cycle late.
    for (genvar k = 1; k < SI_W - 1; k++) begin : g_mid
        localparam logic [31:0] IDX = 32'(k);
        a_r6_index_gate: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[k] == ($past(soft_q[k]) && (32'($past(level_q)) < IDX)));
    end

endmodule

bind swint_mask_unit swint_mask_chk #(
    .SI_W        (SI_W),
    .PIL_W       (PIL_W),
    .DATA_W      (DATA_W),
    .FIXED_LIMIT (FIXED_LIMIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .timer_hit (timer_hit),
    .soft_q    (soft_q),
    .level_q   (level_q),
    .irq_req   (irq_req)
);

// File: tb/tb_swint_mask_unit.sv
`timescale 1ns/1ps
module tb_swint_mask_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic        timer_hit;
    logic [1:0]  rd_addr;
    logic [31:0] rd_data;
    logic [16:0] irq_req;

    always #2 clk = ~clk;

    swint_mask_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .timer_hit (timer_hit),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq_req   (irq_req)
    );

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 0;

    // Reference state: word, level, visible requests, read location.
    int m_reg = 0;
    int m_pil = 15;
    int m_irq = 0;
    int m_rda = 0;

    function automatic int gate_model(int r, int p);
        int g = 0;
        for (int b = 0; b < 17; b++) begin
            if (((r >> b) & 1) == 1) begin
                if (b == 0 || b == 16) begin
                    if (p < 14) g |= (1 << b);
                end else if (b > p) begin
                    g |= (1 << b);
                end
            end
        end
        return g;
    endfunction

    task automatic check(string tag);
        int exp_rd;
        exp_rd = (m_rda == 3) ? m_pil : m_reg;
        n_checks++;
        if (irq_req !== 17'(m_irq)) begin
            n_errs++;
            $display("FAIL %s irq_req got %h expected %h", tag, irq_req, 17'(m_irq));
        end
        n_checks++;
        if (rd_data !== 32'(exp_rd)) begin
            n_errs++;
            $display("FAIL %s rd_data got %h expected %h", tag, rd_data, 32'(exp_rd));
        end
    endtask

    // Check the present outputs, drive one cycle of stimulus, advance the model.
    task automatic step(bit we, int addr, logic [31:0] d, bit hit, int ra, string tag);
        int nr;
        int np;
        int dd;
        @(negedge clk);
        check(tag);
        wr_en     = we;
        wr_addr   = addr[1:0];
        wr_data   = d;
        timer_hit = hit;
        rd_addr   = ra[1:0];
        dd = int'(d);
        nr = m_reg;
        np = m_pil;
        if (we) begin
            case (addr)
                0: nr = dd & 'h1FFFF;
                1: nr = m_reg | (dd & 'h1FFFF);
                2: nr = m_reg & ~dd & 'h1FFFF;
                default: np = dd & 15;
            endcase
        end
        if (hit) nr |= 1;
        @(posedge clk);
        m_irq = gate_model(m_reg, m_pil);
        m_reg = nr;
        m_pil = np;
        m_rda = ra;
    endtask

    task automatic idle(int ra, string tag);
        step(1'b0, 0, 32'h0, 1'b0, ra, tag);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = '0;
        timer_hit = 1'b0; rd_addr = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        idle(3, "R1 reset word and outputs");
        idle(0, "R1 reset level reads 15");
        // R2: over-wide direct load
        step(1'b1, 0, 32'hFFFF_FFFF, 1'b0, 0, "R1 before load");
        idle(0, "R2 upper bits dropped");
        idle(1, "R6 level 15 masks all");
        idle(2, "R10 read via set location");
        // R8: level write with junk upper bits
        step(1'b1, 3, 32'hFFFF_FFFD, 1'b0, 3, "R10 read via clear location");
        idle(3, "R8 level reads 13");
        idle(0, "R7 level 13 passes end bits");
        step(1'b1, 3, 32'd14, 1'b0, 0, "R6 level 13");
        idle(0, "R9 one cycle after level write");
        idle(0, "R7 level 14 masks end bits");
        step(1'b1, 3, 32'd0, 1'b0, 0, "R6 level 14 passes only bit 15");
        idle(0, "R9 level 0 latency");
        idle(0, "R6 level 0 passes bits 1 to 15");
        // R4: clear alias
        step(1'b1, 2, 32'h0001_F0F1, 1'b0, 1, "R6 level 0 steady");
        idle(0, "R4 clear alias word");
        idle(0, "R4 clear alias requests");
        // R3: set alias
        step(1'b1, 1, 32'h0001_0003, 1'b0, 2, "R4 steady");
        idle(0, "R3 set alias word");
        idle(0, "R3 set alias requests");
        // R5: strobe with clear of bit 0 in the same cycle
        step(1'b1, 2, 32'h0000_0001, 1'b1, 0, "R3 steady");
        idle(0, "R5 strobe beats clear");
        step(1'b1, 2, 32'h0001_FFFF, 1'b0, 0, "R5 requests after strobe");
        idle(0, "R4 clear all");
        step(1'b0, 0, 32'h0, 1'b1, 0, "R4 all cleared");
        idle(0, "R5 strobe alone sets bit 0");
        step(1'b1, 3, 32'd13, 1'b0, 0, "R5 requests at level 0");
        idle(0, "R7 bit 0 at level 13");
        idle(0, "R7 bit 0 request");

        for (int i = 0; i < 3000; i++) begin
            int      sel;
            logic [31:0] d;
            sel = int'($urandom_range(0, 3));
            d = $urandom();
            if (sel == 3) d = $urandom_range(10, 17) | (d & 32'hFFFF_FFF0);
            step(($urandom_range(0, 2) != 0), sel, d,
                 ($urandom_range(0, 7) == 0), int'($urandom_range(0, 3)),
                 "R9 random traffic");
        end
        idle(0, "R9 final");
        @(negedge clk);
        check("R9 final");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errs++;
            $display("FAIL R9 watchdog expired got running expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

endmodule